// File: doc/BRIEF.md
# Keyboard Serial Frame Receiver

This block takes in bytes from a keyboard over a two-wire link, a clock line and a data line, where the keyboard drives the clock. Each line passes through a flop synchronizer into the system clock domain. Edges are then found on the synchronized clock. A frame begins with the data line held low as a start bit. Eight data bits follow, least significant first, and then one parity bit. The block samples each of these nine bits on a rising edge of the keyboard clock. The total count of ones in the data and parity bits must be odd. The frame closes when the keyboard pulls the data line low.

A byte with correct parity is stored in a small receive queue that the host drains through a valid/ready port. When the queue is empty the read data shows 0xFF. A parity failure, a bad start or a stalled frame throws away the partial byte. Any of these also raises a one-cycle resend request toward the transmit side. The resend command code on that side is fixed at 0xFE. A separate inhibit input drives an open-drain enable that pulls the data line low, which stops the keyboard from sending.

The frame state machine has four states:
- `ST_IDLE`: waits for the start.
- `ST_DATA`: collects eight bits.
- `ST_PARITY`: takes the parity bit and judges it.
- `ST_STOP`: waits for the data line to go low.

Its transitions are:
- IDLE→DATA on a clock falling edge while data is low (start). A falling edge with data high is a bad start: the machine stays in IDLE and requests a resend.
- DATA→PARITY on the eighth rising edge.
- PARITY→STOP on the ninth rising edge.
- STOP→IDLE when data is low.
- Any non-idle state → IDLE on timeout.

Top module: `kbd_rx`

## Requirements
- R1: In `ST_IDLE`, a falling edge of the synchronized keyboard clock with data low starts a frame. A falling edge with data high is a bad start: it starts no frame and raises a resend request.
- R2: Within a frame, the data line is sampled on each rising clock edge. The first eight samples form the byte, with the first sample as bit 0. The ninth sample is the parity bit.
- R3: The frame is good when the eight data bits plus the parity bit hold an odd number of ones. A good byte is pushed into the queue. A bad frame is discarded and pushes nothing.
- R4: Every error raises `resend_req` as a one-cycle pulse. `resend_code` always reads 0xFE.
- R5: After the parity bit, the machine waits in `ST_STOP` until the synchronized data line is low, then returns to `ST_IDLE`.
- R6: If `TIMEOUT_US` ticks of `tick_us` pass in a non-idle state with no keyboard clock edge, the frame is aborted with a resend request. The next frame is then received normally.
- R7: The queue holds `FIFO_DEPTH` bytes in arrival order. `rd_valid` is high while the queue is non-empty. A byte leaves the queue on a cycle with `rd_valid` and `rd_ready` both high.
- R8: While the queue is empty, `rd_data` reads 0xFF.
- R9: A good byte that completes while the queue is full is dropped, unless a read takes place in the same cycle; in that case the byte is stored.
- R10: `kb_data_oe` (1 = pull data line low) follows `inhibit` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond, drives the timeout |
| kb_clk_i | input | 1 | Keyboard clock line, asynchronous |
| kb_data_i | input | 1 | Keyboard data line, asynchronous |
| inhibit | input | 1 | Request to hold the keyboard off |
| kb_data_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| rd_valid | output | 1 | Receive queue holds a byte |
| rd_ready | input | 1 | Host takes the head byte |
| rd_data | output | 8 | Head byte of the queue, 0xFF when empty |
| resend_req | output | 1 | One-cycle pulse asking the transmit side to send the resend command |
| resend_code | output | 8 | Resend command byte, 0xFE |

## Verification
A good byte can finish and enter the queue in the same cycle that the host reads the head of a full queue. When that happens, the read frees a slot and the new byte must be kept. To provoke this, the bench fills the queue with four frames. It then pulses `rd_ready` for exactly one cycle, timed to the cycle in which the fifth byte's write lands after the ninth rising edge. The bench judges the outcome by draining the queue and expecting the second through fifth bytes in order, followed by 0xFF. A cycle-level reference model checks every output on every clock as well.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2,
        ST_STOP   = 2'd3
    } rx_state_e;

    localparam int          BYTE_W     = 8;
    localparam logic [7:0]  RESEND_CMD = 8'hFE;
    localparam logic [7:0]  EMPTY_BYTE = 8'hFF;
endpackage

// File: rtl/kbd_rx_sync.sv
module kbd_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kb_clk_i,
    input  logic kb_data_i,
    output logic data_s,
    output logic clk_rise,
    output logic clk_fall
);
    logic [STAGES-1:0] clk_ff;
    logic [STAGES-1:0] data_ff;
    logic              clk_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        clk_ff[g]  <= 1'b1;
                        data_ff[g] <= 1'b1;
                    end else begin
                        clk_ff[g]  <= kb_clk_i;
                        data_ff[g] <= kb_data_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        clk_ff[g]  <= 1'b1;
                        data_ff[g] <= 1'b1;
                    end else begin
                        clk_ff[g]  <= clk_ff[g-1];
                        data_ff[g] <= data_ff[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= clk_ff[STAGES-1];
    end

    assign data_s   = data_ff[STAGES-1];
    assign clk_rise =  clk_ff[STAGES-1] & ~clk_prev;
    assign clk_fall = ~clk_ff[STAGES-1] &  clk_prev;
endmodule

// File: rtl/kbd_rx_fsm.sv
module kbd_rx_fsm
    import kbd_rx_pkg::*;
#(
    parameter int TIMEOUT_US = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              clk_rise,
    input  logic              clk_fall,
    input  logic              data_s,
    output logic              push,
    output logic [BYTE_W-1:0] push_byte,
    output logic              resend_req
);
    localparam int TW = (TIMEOUT_US > 1) ? $clog2(TIMEOUT_US) : 1;
    localparam int IW = $clog2(BYTE_W);

    rx_state_e         state, state_n;
    logic [BYTE_W-1:0] shreg;
    logic [IW-1:0]     bit_idx;
    logic [TW-1:0]     tmo_cnt;
    logic              any_edge, timeout, bad_start, frame_end, parity_ok;

    always_comb begin
        any_edge  = clk_rise | clk_fall;
        timeout   = (state != ST_IDLE) && tick_us && !any_edge &&
                    (tmo_cnt == TW'(TIMEOUT_US - 1));
        bad_start = (state == ST_IDLE) && clk_fall && data_s;
        frame_end = (state == ST_PARITY) && clk_rise;
        parity_ok = ^{shreg, data_s};
        state_n   = state;
        unique case (state)
            ST_IDLE:   if (clk_fall && !data_s) state_n = ST_DATA;
            ST_DATA:   if (clk_rise && bit_idx == IW'(BYTE_W - 1)) state_n = ST_PARITY;
            ST_PARITY: if (clk_rise) state_n = ST_STOP;
            ST_STOP:   if (!data_s) state_n = ST_IDLE;
        endcase
        if (timeout) state_n = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            tmo_cnt <= '0;
        end else begin
            if (state == ST_IDLE) begin
                shreg   <= '0;
                bit_idx <= '0;
            end else if (state == ST_DATA && clk_rise) begin
                shreg   <= {data_s, shreg[BYTE_W-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
            if (state == ST_IDLE || any_edge || timeout) tmo_cnt <= '0;
            else if (tick_us)                            tmo_cnt <= tmo_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push       <= 1'b0;
            push_byte  <= '0;
            resend_req <= 1'b0;
        end else begin
            push       <= frame_end && parity_ok;
            resend_req <= (frame_end && !parity_ok) || bad_start || timeout;
            if (frame_end) push_byte <= shreg;
        end
    end

    a_r1_start_enters_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && clk_fall && !data_s) |=> (state == ST_DATA));
    a_r5_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !data_s && !timeout) |=> (state == ST_IDLE));
    a_r3_push_excludes_resend: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && resend_req));
    a_r6_timeout_leaves_frame: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (state == ST_IDLE && resend_req));
endmodule

// File: rtl/kbd_rx_fifo.sv
module kbd_rx_fifo
    import kbd_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_byte,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              full, pop, accept;

    assign full     = (count == CW'(DEPTH));
    assign rd_valid = (count != '0);
    assign pop      = rd_valid && rd_ready;
    assign accept   = push && (!full || pop);
    assign rd_data  = rd_valid ? mem[rd_ptr] : EMPTY_BYTE;

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)    rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(accept) - CW'(pop);
        end
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r7_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/kbd_rx.sv
module kbd_rx
    import kbd_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int TIMEOUT_US  = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       kb_clk_i,
    input  logic       kb_data_i,
    input  logic       inhibit,
    output logic       kb_data_oe,
    output logic       rd_valid,
    input  logic       rd_ready,
    output logic [7:0] rd_data,
    output logic       resend_req,
    output logic [7:0] resend_code
);
    logic              data_s, clk_rise, clk_fall, push;
    logic [BYTE_W-1:0] push_byte;

    kbd_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk_i), .kb_data_i(kb_data_i),
        .data_s(data_s), .clk_rise(clk_rise), .clk_fall(clk_fall)
    );

    kbd_rx_fsm #(.TIMEOUT_US(TIMEOUT_US)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .clk_rise(clk_rise),
        .clk_fall(clk_fall), .data_s(data_s), .push(push),
        .push_byte(push_byte), .resend_req(resend_req)
    );

    kbd_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_byte(push_byte),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) kb_data_oe <= 1'b0;
        else        kb_data_oe <= inhibit;
    end

    assign resend_code = RESEND_CMD;

    a_r10_inhibit_drive: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> kb_data_oe);
endmodule

// File: tb/kbd_rx_bench.sv
module kbd_rx_bench;
    localparam int DEPTH = 4;
    localparam int TMO   = 20;

    logic       clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0;
    logic       kb_clk_i = 1'b1, kb_data_i = 1'b1, inhibit = 1'b0, rd_ready = 1'b0;
    logic       kb_data_oe, rd_valid, resend_req;
    logic [7:0] rd_data, resend_code;

    int total = 0, fails = 0, n_resend = 0, tick_div = 0;
    bit done = 0;

    kbd_rx #(.FIFO_DEPTH(DEPTH), .TIMEOUT_US(TMO), .SYNC_STAGES(2)) u_kbd_rx (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .kb_clk_i(kb_clk_i),
        .kb_data_i(kb_data_i), .inhibit(inhibit), .kb_data_oe(kb_data_oe),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .resend_req(resend_req), .resend_code(resend_code)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
        end
    endtask

    // Reference model: behavioural, stepped on every rising clock edge
    logic [7:0] q[$];
    bit ch1, ch2, ch3, dh1, dh2, m_push, m_res, m_oe;
    int st, idx, cnt;
    logic [7:0] sh, m_byte;

    always @(posedge clk) begin
        if (!rst_n) begin
            ch1 = 1; ch2 = 1; ch3 = 1; dh1 = 1; dh2 = 1;
            m_push = 0; m_res = 0; m_oe = 0; st = 0; idx = 0; cnt = 0;
            sh = 0; m_byte = 0; q.delete();
        end else begin
            bit rise, fall, d, anye, to, np, nr;
            int st_n;
            rise = ch2 && !ch3; fall = !ch2 && ch3; d = dh2; anye = rise || fall;
            if (q.size() > 0 && rd_ready) void'(q.pop_front());
            if (m_push && q.size() < DEPTH) q.push_back(m_byte);
            to = (st != 0) && tick_us && !anye && (cnt == TMO - 1);
            np = 0; nr = 0; st_n = st;
            case (st)
                0: if (fall) begin if (d) nr = 1; else st_n = 1; end
                1: if (rise) begin
                       sh = {d, sh[7:1]}; idx++;
                       if (idx == 8) st_n = 2;
                   end
                2: if (rise) begin
                       if ((($countones(sh) + d) % 2) == 1) begin np = 1; m_byte = sh; end
                       else nr = 1;
                       st_n = 3;
                   end
                default: if (!d) st_n = 0;
            endcase
            if (to) begin st_n = 0; nr = 1; end
            if (st == 0 || anye || to) cnt = 0; else if (tick_us) cnt++;
            if (st == 0) begin sh = 0; idx = 0; end
            m_push = np; m_res = nr; st = st_n; m_oe = inhibit;
            ch3 = ch2; ch2 = ch1; ch1 = kb_clk_i; dh2 = dh1; dh1 = kb_data_i;
            if (resend_req) n_resend++;
        end
    end

    always @(negedge clk) begin
        tick_us <= (tick_div % 2 == 0);
        tick_div++;
        if (rst_n) begin
            logic [7:0] exp_d;
            exp_d = (q.size() > 0) ? q[0] : 8'hFF;
            check(rd_valid === (q.size() > 0), "R7 model rd_valid", rd_valid, q.size() > 0);
            check(rd_data === exp_d, "R8 model rd_data", rd_data, exp_d);
            check(resend_req === m_res, "R4 model resend_req", resend_req, m_res);
            check(kb_data_oe === m_oe, "R10 model kb_data_oe", kb_data_oe, m_oe);
        end
    end

    task automatic send_frame(input logic [7:0] b, input bit flip_par, input bit pop_end);
        logic [8:0] bits;
        bits = {(~^b) ^ flip_par, b};
        @(negedge clk) kb_data_i = 0;
        repeat (15) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            kb_clk_i = 0; @(negedge clk);
            kb_data_i = bits[i]; repeat (2) @(negedge clk);
            kb_clk_i = 1;
            if (i == 8 && pop_end) begin
                repeat (3) @(negedge clk);
                rd_ready = 1; @(negedge clk); rd_ready = 0;
                repeat (2) @(negedge clk);
            end else repeat (6) @(negedge clk);
        end
        kb_data_i = 0; repeat (4) @(negedge clk);
        kb_data_i = 1; repeat (10) @(negedge clk);
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string req);
        @(negedge clk);
        check(rd_valid === 1'b1 && rd_data === exp, req, rd_data, exp);
        rd_ready = 1; @(negedge clk); rd_ready = 0;
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        check(rd_valid === 1'b0 && rd_data === 8'hFF, req, rd_data, 8'hFF);
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        check(rd_valid === 0 && rd_data === 8'hFF, "R8 reset empty", rd_data, 8'hFF);
        check(resend_req === 0 && kb_data_oe === 0, "R4 reset quiet", resend_req, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(resend_code === 8'hFE, "R4 resend code", resend_code, 8'hFE);

        // R2 R3 good byte, LSB first
        send_frame(8'hA5, 0, 0);
        pop_expect(8'hA5, "R2 byte A5");
        send_frame(8'h01, 0, 0);
        pop_expect(8'h01, "R2 byte 01 bit order");
        expect_empty("R8 empty after drain");

        // R3 R4 parity error
        r0 = n_resend;
        send_frame(8'h3C, 1, 0);
        check(n_resend == r0 + 1, "R3 parity error resend", n_resend, r0 + 1);
        expect_empty("R3 bad byte discarded");

        // R1 bad start
        r0 = n_resend;
        @(negedge clk) kb_clk_i = 0; repeat (3) @(negedge clk);
        kb_clk_i = 1; repeat (10) @(negedge clk);
        check(n_resend == r0 + 1, "R1 bad start resend", n_resend, r0 + 1);
        expect_empty("R1 bad start no byte");

        // R6 timeout
        r0 = n_resend;
        @(negedge clk) kb_data_i = 0; repeat (15) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            kb_clk_i = 0; repeat (3) @(negedge clk);
            kb_clk_i = 1; repeat (6) @(negedge clk);
        end
        repeat (100) @(negedge clk);
        kb_data_i = 1; repeat (10) @(negedge clk);
        check(n_resend == r0 + 1, "R6 timeout resend", n_resend, r0 + 1);
        expect_empty("R6 aborted no byte");
        send_frame(8'h81, 0, 0);
        pop_expect(8'h81, "R6 recovery byte 81");

        // R7 R9 order and overflow drop
        for (int k = 1; k <= 5; k++) send_frame(8'(k), 0, 0);
        for (int k = 1; k <= 4; k++) pop_expect(8'(k), "R9 kept bytes in order");
        expect_empty("R9 fifth byte dropped");

        // R9 R7 completion on a full queue with a read in the same cycle
        for (int k = 'h10; k <= 'h13; k++) send_frame(8'(k), 0, 0);
        send_frame(8'h14, 0, 1);
        for (int k = 'h11; k <= 'h14; k++) pop_expect(8'(k), "R9 pop with push accepted");
        expect_empty("R7 drained");

        // R10 inhibit
        @(negedge clk) inhibit = 1; @(negedge clk);
        check(kb_data_oe === 1, "R10 inhibit pulls low", kb_data_oe, 1);
        inhibit = 0; @(negedge clk);
        check(kb_data_oe === 0, "R10 inhibit released", kb_data_oe, 0);

        // R5 stop reached: next frame accepted
        send_frame(8'h5A, 0, 0);
        pop_expect(8'h5A, "R5 frame after stop");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule